// File: doc/BRIEF.md
# Two-Level Banked Interrupt Controller

This block gathers 72 level-sensitive interrupt sources into three banks. Bank 0 holds 8 direct sources, and banks 1 and 2 hold 32 sources each. Each source is masked on its own, through write-one-to-set and write-one-to-clear enable registers. A small synchronous register bus gives access to these registers. The bus has an address, a write strobe, write data and a combinational read-data path.

A top-level summary register helps the handler find the right bank quickly. It shows the bank 0 sources directly and has one summary bit each for banks 1 and 2. It also has a group of shortcut bits that mirror eleven selected sources of banks 1 and 2. A source with a shortcut never raises its bank's summary bit. Nothing can be masked at the top level.

One source can be routed to a separate fast-interrupt output. It is chosen by a 7-bit index that counts bank 1 first, then bank 2, then bank 0. The routed source is then removed from the normal interrupt output.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset, all enable masks and the fast-interrupt control register read 0. Every pending register reads 0, and `irq_o` and `fiq_o` are low.
- R2: The enable-set register of each bank adds the 1 bits of the written word to that bank's enable mask. The offsets are 0x10 for bank 1, 0x14 for bank 2 and 0x18 for bank 0. The enable-clear register removes the 1 bits of the written word. Its offsets are 0x1C for bank 1, 0x20 for bank 2 and 0x24 for bank 0. Zero bits leave the mask unchanged. Reading either register of a bank returns that bank's current mask, zero-extended for bank 0.
- R3: The bank pending registers read the bitwise AND of the source inputs and the bank's enable mask, with nothing latched. The offsets are 0x04 for bank 1 and 0x08 for bank 2.
- R4: Bits 7:0 of the summary register at offset 0x00 equal the enabled, active bank 0 sources. Bits 31:21 always read 0.
- R5: The shortcut bits of the summary register mirror enabled, active sources as follows:
  - Bits 10 to 14 mirror bank 1 sources 7, 9, 10, 18 and 19, in that order.
  - Bits 15 to 20 mirror bank 2 sources 21, 22, 23, 24, 25 and 30, in that order.
- R6: Summary bit 8 is set only when an enabled, active bank 1 source without a shortcut exists. Summary bit 9 follows the same rule for bank 2. Shortcut sources still set their own bit in the bank pending register.
- R7: The bank 0 enable registers act only on bits 7:0. Writing the shortcut positions (bits 10 to 20) of these registers has no effect on any enable or on any pending bit. Shortcut sources are masked only in their own bank.
- R8: The fast-interrupt control register at offset 0x0C keeps the source index in bits 6:0 and the routing enable in bit 7. Bits 31:8 read 0. Index values 0 to 31 select bank 1 sources, 32 to 63 select bank 2 sources, and 64 to 71 select bank 0 sources 0 to 7. Indices 72 to 127 select no source.
- R9: `fiq_o` equals the raw input level of the selected source while the routing enable is 1, whatever that source's enable bit is. It is 0 otherwise.
- R10: `irq_o` is the OR of all enabled, active sources. While routing is enabled and the index is valid, the selected source is excluded from this OR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_b0 | input | 8 | Bank 0 source levels |
| src_b1 | input | 32 | Bank 1 source levels |
| src_b2 | input | 32 | Bank 2 source levels |
| bus_addr | input | 6 | Register byte offset |
| bus_we | input | 1 | Write strobe, one write per clock |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Normal interrupt output |
| fiq_o | output | 1 | Fast interrupt output |

## Verification
The assertions assume that the bus address, write strobe and write data are known and stable around each rising edge once reset is released. They also assume that each asserted write strobe stands for exactly one register write. The stimulus keeps within these assumptions by changing every bus input and every source level only at the falling edge. It lowers the write strobe after a single cycle. It samples the combinational read data and both outputs a short time after that edge, so the register state is settled.

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        src_b0,
  input  logic [31:0]       src_b1,
  input  logic [31:0]       src_b2,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_o,
  output logic              fiq_o
);
  localparam logic [ADDR_W-1:0] A_TOP  = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] A_PND1 = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] A_PND2 = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] A_FIQ  = ADDR_W'('h0C);
  localparam logic [ADDR_W-1:0] A_SET1 = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] A_SET2 = ADDR_W'('h14);
  localparam logic [ADDR_W-1:0] A_SET0 = ADDR_W'('h18);
  localparam logic [ADDR_W-1:0] A_CLR1 = ADDR_W'('h1C);
  localparam logic [ADDR_W-1:0] A_CLR2 = ADDR_W'('h20);
  localparam logic [ADDR_W-1:0] A_CLR0 = ADDR_W'('h24);
  localparam logic [31:0] SC1 = 32'h000C_0680;
  localparam logic [31:0] SC2 = 32'h43E0_0000;
  localparam int NSRC = 72;

  logic [7:0]  en0;
  logic [31:0] en1, en2;
  logic [7:0]  fiq_ctl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en0 <= '0;
      en1 <= '0;
      en2 <= '0;
      fiq_ctl <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        A_FIQ:  fiq_ctl <= bus_wdata[7:0];
        A_SET1: en1 <= en1 | bus_wdata;
        A_SET2: en2 <= en2 | bus_wdata;
        A_SET0: en0 <= en0 | bus_wdata[7:0];
        A_CLR1: en1 <= en1 & ~bus_wdata;
        A_CLR2: en2 <= en2 & ~bus_wdata;
        A_CLR0: en0 <= en0 & ~bus_wdata[7:0];
        default: ;
      endcase
    end
  end

  logic [7:0]  p0;
  logic [31:0] p1, p2, top;
  assign p0 = src_b0 & en0;
  assign p1 = src_b1 & en1;
  assign p2 = src_b2 & en2;

  assign top = {11'd0,
                p2[30], p2[25:21],
                p1[19], p1[18], p1[10], p1[9], p1[7],
                |(p2 & ~SC2), |(p1 & ~SC1),
                p0};

  always_comb begin
    case (bus_addr)
      A_TOP:          bus_rdata = top;
      A_PND1:         bus_rdata = p1;
      A_PND2:         bus_rdata = p2;
      A_FIQ:          bus_rdata = {24'd0, fiq_ctl};
      A_SET1, A_CLR1: bus_rdata = en1;
      A_SET2, A_CLR2: bus_rdata = en2;
      A_SET0, A_CLR0: bus_rdata = {24'd0, en0};
      default:        bus_rdata = '0;
    endcase
  end

  logic [NSRC-1:0] raw_all, pnd_all, fiq_sel;
  logic            fiq_on;
  assign raw_all = {src_b0, src_b2, src_b1};
  assign pnd_all = {p0, p2, p1};
  assign fiq_on  = fiq_ctl[7] && (fiq_ctl[6:0] < 7'(NSRC));
  assign fiq_sel = fiq_on ? (NSRC'(1) << fiq_ctl[6:0]) : '0;
  assign fiq_o   = |(raw_all & fiq_sel);
  assign irq_o   = |(pnd_all & ~fiq_sel);
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        src_b0,
  input logic [31:0]       src_b1,
  input logic [31:0]       src_b2,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              irq_o,
  input logic              fiq_o,
  input logic [7:0]        en0,
  input logic [31:0]       en1,
  input logic [31:0]       en2,
  input logic [7:0]        fiq_ctl
);
  localparam logic [31:0] NOSC1 = ~32'h000C_0680;

  // R1
  rst_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (en0 == 8'd0 && en1 == 32'd0 && en2 == 32'd0 && fiq_ctl == 8'd0));

  // R2
  en1_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'('h10)) |=> en1 == ($past(en1) | $past(bus_wdata)));

  // R2
  en1_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'('h1C)) |=> en1 == ($past(en1) & ~$past(bus_wdata)));

  // R7
  en0_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && (bus_addr == ADDR_W'('h18) || bus_addr == ADDR_W'('h24)) && bus_wdata[7:0] == 8'd0)
    |=> $stable(en0));

  // R6
  summary1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'('h00) && bus_rdata[8]) |-> |(src_b1 & en1 & NOSC1));

  // R8
  fiq_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'('h0C)) |-> bus_rdata[31:8] == 24'd0);

  // R9
  fiq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o |-> fiq_ctl[7]);

  // R10
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (|(src_b0 & en0) || |(src_b1 & en1) || |(src_b2 & en2)));
endmodule

bind banked_irq_ctrl irq_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_banked_irq_ctrl.sv
`timescale 1ns/1ps
module sim_banked_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [71:0] srcv = '0;
  logic [5:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, fiq_o;

  banked_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n),
    .src_b0(srcv[71:64]), .src_b1(srcv[31:0]), .src_b2(srcv[63:32]),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  always #2 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [71:0] m_en = '0;
  logic [7:0]  m_fiq = '0;

  // bank order in the model: 0 = bank 1, 1 = bank 2, 2 = bank 0
  function automatic logic [5:0] set_off(int b);
    return (b == 0) ? 6'h10 : (b == 1) ? 6'h14 : 6'h18;
  endfunction
  function automatic logic [5:0] clr_off(int b);
    return (b == 0) ? 6'h1C : (b == 1) ? 6'h20 : 6'h24;
  endfunction
  function automatic logic [5:0] pnd_off(int b);
    return (b == 0) ? 6'h04 : (b == 1) ? 6'h08 : 6'h00;
  endfunction

  function automatic int sc_pos(int g);
    case (g)
      7: return 10;  9: return 11; 10: return 12; 18: return 13; 19: return 14;
      53: return 15; 54: return 16; 55: return 17; 56: return 18; 57: return 19;
      62: return 20;
      default: return -1;
    endcase
  endfunction

  function automatic logic [31:0] exp_top();
    logic [71:0] p;
    logic [31:0] r;
    p = srcv & m_en;
    r = {24'd0, p[71:64]};
    for (int g = 0; g < 64; g++)
      if (p[g]) begin
        if (sc_pos(g) >= 0) r[sc_pos(g)] = 1'b1;
        else r[(g < 32) ? 8 : 9] = 1'b1;
      end
    return r;
  endfunction

  function automatic logic [71:0] sel_vec();
    if (m_fiq[7] && m_fiq[6:0] < 72) return 72'd1 << m_fiq[6:0];
    return '0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic en_set(input int b, input logic [31:0] m);
    wr(set_off(b), m);
    if (b == 2) m_en[71:64] |= m[7:0]; else m_en[b*32 +: 32] |= m;
  endtask

  task automatic en_clr(input int b, input logic [31:0] m);
    wr(clr_off(b), m);
    if (b == 2) m_en[71:64] &= ~m[7:0]; else m_en[b*32 +: 32] &= ~m;
  endtask

  task automatic check_all(input string tag);
    logic [31:0] d;
    logic [71:0] p;
    p = srcv & m_en;
    rd(6'h00, d); chk({tag, " top"}, d, exp_top());
    rd(6'h04, d); chk({tag, " pnd1"}, d, p[31:0]);
    rd(6'h08, d); chk({tag, " pnd2"}, d, p[63:32]);
    chk({tag, " irq"}, {31'd0, irq_o}, {31'd0, |(p & ~sel_vec())});
    chk({tag, " fiq"}, {31'd0, fiq_o}, {31'd0, |(srcv & sel_vec())});
  endtask

  initial begin
    logic [31:0] d;
    logic [31:0] acc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a <= 6'h24; a += 4) begin
      rd(6'(a), d); chk("R1 reset read", d, 32'd0);
    end
    chk("R1 irq reset", {31'd0, irq_o}, 32'd0);
    chk("R1 fiq reset", {31'd0, fiq_o}, 32'd0);

    // R2 enable set/clear sweep
    for (int b = 0; b < 3; b++) begin
      int w;
      w = (b == 2) ? 8 : 32;
      acc = 0;
      for (int i = 0; i < w; i++) begin
        en_set(b, 32'd1 << i); acc |= 32'd1 << i;
        rd(set_off(b), d); chk("R2 set readback", d, acc);
        rd(clr_off(b), d); chk("R2 clr-reg readback", d, acc);
      end
      for (int i = 0; i < w; i += 2) begin
        en_clr(b, 32'd1 << i); acc &= ~(32'd1 << i);
        rd(clr_off(b), d); chk("R2 clear readback", d, acc);
      end
      en_set(b, 32'h0); rd(set_off(b), d); chk("R2 zero write", d, acc);
      en_clr(b, 32'h0); rd(set_off(b), d); chk("R2 zero clear", d, acc);
      en_clr(b, 32'hFFFF_FFFF);
    end

    // R7 bank 0 enables ignore shortcut positions
    wr(6'h18, 32'h001F_FC00);
    rd(6'h18, d); chk("R7 bank0 set upper ignored", d, 32'd0);
    wr(6'h18, 32'hFFFF_FFFF); m_en[71:64] = 8'hFF;
    rd(6'h24, d); chk("R7 bank0 mask width", d, 32'h0000_00FF);
    en_clr(2, 32'hFF);

    // R3 R4 R5 R6 R10 single-source sweep with all enables on
    en_set(0, 32'hFFFF_FFFF); en_set(1, 32'hFFFF_FFFF); en_set(2, 32'hFF);
    for (int g = 0; g < 72; g++) begin
      int b, n;
      b = (g < 32) ? 0 : (g < 64) ? 1 : 2;
      n = g - b * 32;
      @(negedge clk); srcv = 72'd1 << g;
      check_all("R3 R4 R5 R6 R10 single");
      en_clr(b, 32'd1 << n);
      check_all("R3 R10 masked");
      en_set(b, 32'd1 << n);
    end

    // R5 R6 mixes of shortcut and plain sources
    @(negedge clk); srcv = '0; srcv[7] = 1; srcv[62] = 1; srcv[19] = 1;
    check_all("R5 R6 shortcuts only");
    @(negedge clk); srcv[0] = 1; srcv[33] = 1;
    check_all("R6 shortcut plus plain");
    @(negedge clk); srcv = {8'hA5, 32'hFFFF_FFFF, 32'h5555_AAAA};
    check_all("R4 R5 R6 dense");

    // R7 shortcut source masked only in own bank
    @(negedge clk); srcv = '0; srcv[7] = 1; srcv[53] = 1;
    wr(6'h24, 32'hFFFF_FF00);
    check_all("R7 bank0 clear on shortcut bits");
    rd(6'h00, d); chk("R7 shortcut still set", d & 32'h0009_8400, 32'h0000_8400);
    en_clr(0, 32'h80);
    check_all("R7 own bank mask");

    // R8 control register width
    wr(6'h0C, 32'hFFFF_FFFF); m_fiq = 8'hFF;
    rd(6'h0C, d); chk("R8 fiq ctl readback", d, 32'h0000_00FF);

    // R8 R9 R10 routing sweep
    en_set(0, 32'hFFFF_FFFF); en_set(1, 32'hFFFF_FFFF); en_set(2, 32'hFF);
    for (int g = 0; g < 72; g++) begin
      int b, n;
      b = (g < 32) ? 0 : (g < 64) ? 1 : 2;
      n = g - b * 32;
      wr(6'h0C, 32'h80 | g); m_fiq = 8'h80 | 8'(g);
      @(negedge clk); srcv = 72'd1 << g;
      check_all("R8 R9 R10 routed enabled");
      en_clr(b, 32'd1 << n);
      check_all("R9 routed raw level");
      en_set(b, 32'd1 << n);
      @(negedge clk); srcv = 72'd1 << ((g + 1) % 72);
      check_all("R10 other source");
      wr(6'h0C, g); m_fiq = 8'(g);
      @(negedge clk); srcv = 72'd1 << g;
      check_all("R9 R10 routing off");
    end

    // R8 out-of-range index selects nothing
    @(negedge clk); srcv = '1;
    for (int i = 72; i < 128; i += 7) begin
      wr(6'h0C, 32'h80 | i); m_fiq = 8'h80 | 8'(i);
      check_all("R8 invalid index");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired got 0 exp 1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule